// File: doc/BRIEF.md
# PECI Host Controller Register Front-End

This block is the software-facing side of a PECI host controller. Through a simple single-cycle register bus, software sets the target address, a command byte, the outgoing and incoming byte counts, a pull-down setting and a bit-rate negotiation value. It also fills a small bank of byte-wide data slots. Writing the start bit launches a transaction. The front-end then hands every setting to a separate transfer engine. That engine serializes the bytes on the wire. This block does not cover the wire encoding.

While a transaction is in flight, the engine reads outgoing bytes from the data bank by index and writes received bytes back into the same slots. It ends the transaction with a single completion pulse, which carries a CRC-error flag and an abort flag. The front-end records the result in sticky status bits that software clears by writing 1. It raises a level interrupt while any result bit is set, provided the interrupt is enabled. Software then reads the received bytes from the bank.

Top module: `peci_host_frontend`

## Requirements
- R1: After reset every register reads 0, except the bit-rate register at offset 0x2C, which reads 15 (0x0F). The interrupt output is low.
- R2: Writing a word with bit 0 set to offset 0x00 while idle does three things in the next cycle: bit 0 (busy) reads 1, `eng_start` is high for exactly one cycle, and the engine outputs present the programmed address, command and lengths.
- R3: Busy stays 1 until the engine completion pulse. From the following cycle, busy reads 0 and done (bit 1 of offset 0x00) reads 1.
- R4: Done is set on every completion, including completions that report an error. CRC error (bit 3) and abort (bit 4) are captured from the engine flags in the same edge as done.
- R5: Writing 1 to bit 1, 3 or 4 of offset 0x00 clears that bit, and writing 0 leaves it unchanged. If a completion arrives in the same cycle as a clearing write, the bit is set.
- R6: Bit 6 of offset 0x00 is the interrupt enable. `irq` is high exactly while the enable is 1 and at least one of done, CRC error or abort is set.
- R7: While busy is 1, the following writes are ignored: a second start, and writes to the address, command, length and data registers.
- R8: Read length is bits 6:0 of offset 0x04 and write length is bits 6:0 of offset 0x1C. The target address is bits 7:0 of offset 0x08 and the command byte is bits 7:0 of offset 0x0C.
- R9: Data slot i sits at offset 0x100 + 4*i, in bits 7:0. The engine reads it via `eng_tx_idx`/`eng_tx_byte`. Bytes the engine writes during a transaction read back from the same offsets.
- R10: The pull-down setting is bits 7:6 of offset 0x10 and the bit-rate value is bits 4:0 of offset 0x2C. Both are writable at any time and are driven to the engine.
- R11: Unmapped offsets read 0 and ignore writes. This includes data offsets beyond the bank depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (same cycle) |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_tgt | output | 8 | Target address |
| eng_cmd | output | 8 | Command byte |
| eng_wr_len | output | 7 | Outgoing byte count |
| eng_rd_len | output | 7 | Incoming byte count |
| eng_rate | output | 5 | Bit-rate negotiation value |
| eng_pulldn | output | 2 | Pull-down setting |
| eng_tx_idx | input | IDX_W | Slot the engine reads |
| eng_tx_byte | output | 8 | Content of that slot |
| eng_rx_we | input | 1 | Engine writes a received byte |
| eng_rx_idx | input | IDX_W | Slot for the received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Completion pulse |
| eng_crc_err | input | 1 | CRC error flag, valid with eng_done |
| eng_abort | input | 1 | Abort flag, valid with eng_done |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the engine raises its completion pulse and received-byte writes only after `eng_start`, and before the next start. They also assume that its error flags are meaningful only in the cycle of `eng_done`. Register accesses are word-aligned. The bench's responder honors these conditions: it writes received bytes and pulses completion only between its observation of `eng_start` and the following launch. The single deliberate overlap the bench creates is a clearing write that coincides with the completion pulse, which exercises the set-over-clear rule.

// File: rtl/peci_fe_pkg.sv
// Shared offsets, bit positions and types of the PECI host front-end.
// Assumes byte addressing with word-aligned registers.
package peci_fe_pkg;
    localparam int unsigned OFS_CSR    = 'h00;
    localparam int unsigned OFS_RDLEN  = 'h04;
    localparam int unsigned OFS_TGT    = 'h08;
    localparam int unsigned OFS_CMD    = 'h0C;
    localparam int unsigned OFS_PULL   = 'h10;
    localparam int unsigned OFS_WRLEN  = 'h1C;
    localparam int unsigned OFS_RATE   = 'h2C;
    localparam int unsigned DATA_PAGE  = 1;     // bank lives at 0x100..0x1FF

    localparam int unsigned BIT_BUSY = 0;
    localparam int unsigned BIT_DONE = 1;
    localparam int unsigned BIT_CRC  = 3;
    localparam int unsigned BIT_ABRT = 4;
    localparam int unsigned BIT_IEN  = 6;

    typedef struct packed {
        logic abrt;
        logic crc;
        logic done;
    } fe_status_t;
endpackage

// File: rtl/peci_fe_seq.sv
// Start/busy sequencer with sticky result flags and the interrupt level.
// Assumes the engine pulses done for one cycle per transaction; a
// completion seen while idle is discarded.
module peci_fe_seq
    import peci_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_we,
    input  logic       wr_start,
    input  logic       wr_ien,
    input  logic       clr_done,
    input  logic       clr_crc,
    input  logic       clr_abrt,
    input  logic       eng_done,
    input  logic       eng_crc_err,
    input  logic       eng_abort,
    output logic       busy,
    output logic       start_pulse,
    output logic       ien,
    output fe_status_t sts,
    output logic       irq
);
    logic finish;
    assign finish = busy & eng_done;

    // Launch on an idle start write, release busy on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (finish) begin
                busy <= 1'b0;
            end else if (!busy && csr_we && wr_start) begin
                busy        <= 1'b1;
                start_pulse <= 1'b1;
            end
        end
    end

    // Sticky result flags: a completion sets them, and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            ien <= 1'b0;
        end else begin
            if (csr_we) ien <= wr_ien;
            sts.done <= (sts.done & ~(csr_we & clr_done)) | finish;
            sts.crc  <= (sts.crc  & ~(csr_we & clr_crc))  | (finish & eng_crc_err);
            sts.abrt <= (sts.abrt & ~(csr_we & clr_abrt)) | (finish & eng_abort);
        end
    end

    // Level interrupt from the enabled flags.
    always_comb irq = ien & (sts.done | sts.crc | sts.abrt);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_pulse);
    p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> (!busy && sts.done));
    p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts.crc) || $rose(sts.abrt)) |-> sts.done);
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && clr_done && !(busy && eng_done)) |=> !sts.done);
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !csr_we) |=> irq);
    p_single_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
endmodule

// File: rtl/peci_fe_bank.sv
// Byte-wide data slots shared by software (outgoing) and the engine
// (incoming). Assumes the caller never enables both writers together.
module peci_fe_bank #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [7:0]       bus_wbyte,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [7:0]       eng_wbyte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [7:0]       tx_byte
);
    logic [7:0] slot [DEPTH];

    // One register per slot; the engine writer takes priority.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (eng_we && eng_idx == IDX_W'(g))
                slot[g] <= eng_wbyte;
            else if (bus_we && bus_idx == IDX_W'(g))
                slot[g] <= bus_wbyte;
        end
    end

    // Two independent read ports.
    always_comb begin
        rd_byte = slot[rd_idx];
        tx_byte = slot[tx_idx];
    end

    p_no_dual_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && eng_we));
endmodule

// File: rtl/peci_host_frontend.sv
// Register decode and configuration of the PECI host front-end. It
// launches an external transfer engine and collects its results.
// Assumes ADDR_W > 8 and DEPTH <= 64 (the bank fits in page 1).
module peci_host_frontend
    import peci_fe_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DEPTH    = 16,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int RATE_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_start,
    output logic [7:0]        eng_tgt,
    output logic [7:0]        eng_cmd,
    output logic [6:0]        eng_wr_len,
    output logic [6:0]        eng_rd_len,
    output logic [4:0]        eng_rate,
    output logic [1:0]        eng_pulldn,
    input  logic [IDX_W-1:0]  eng_tx_idx,
    output logic [7:0]        eng_tx_byte,
    input  logic              eng_rx_we,
    input  logic [IDX_W-1:0]  eng_rx_idx,
    input  logic [7:0]        eng_rx_byte,
    input  logic              eng_done,
    input  logic              eng_crc_err,
    input  logic              eng_abort,
    output logic              irq
);
    localparam logic [6:0] DEPTH7 = 7'(DEPTH);

    logic       wr;
    logic       hit_csr, hit_rdlen, hit_tgt, hit_cmd, hit_pull, hit_wrlen, hit_rate, hit_data;
    logic       busy, ien;
    fe_status_t sts;
    logic [7:0] tgt_q, cmd_q;
    logic [6:0] rdlen_q, wrlen_q;
    logic [1:0] pull_q;
    logic [4:0] rate_q;
    logic [7:0] data_rd;
    logic       unused_bits;

    assign wr          = bus_sel & bus_we;
    assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

    // Address decode of every mapped location.
    always_comb begin
        hit_csr   = bus_addr == ADDR_W'(OFS_CSR);
        hit_rdlen = bus_addr == ADDR_W'(OFS_RDLEN);
        hit_tgt   = bus_addr == ADDR_W'(OFS_TGT);
        hit_cmd   = bus_addr == ADDR_W'(OFS_CMD);
        hit_pull  = bus_addr == ADDR_W'(OFS_PULL);
        hit_wrlen = bus_addr == ADDR_W'(OFS_WRLEN);
        hit_rate  = bus_addr == ADDR_W'(OFS_RATE);
        hit_data  = (bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(DATA_PAGE))
                    && ({1'b0, bus_addr[7:2]} < DEPTH7);
    end

    // Transaction settings: frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            cmd_q   <= '0;
            rdlen_q <= '0;
            wrlen_q <= '0;
        end else if (wr && !busy) begin
            if (hit_tgt)   tgt_q   <= bus_wdata[7:0];
            if (hit_cmd)   cmd_q   <= bus_wdata[7:0];
            if (hit_rdlen) rdlen_q <= bus_wdata[6:0];
            if (hit_wrlen) wrlen_q <= bus_wdata[6:0];
        end
    end

    // Line settings: writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= '0;
            rate_q <= 5'(RATE_RST);
        end else if (wr) begin
            if (hit_pull) pull_q <= bus_wdata[7:6];
            if (hit_rate) rate_q <= bus_wdata[4:0];
        end
    end

    peci_fe_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_we      (wr && hit_csr),
        .wr_start    (bus_wdata[BIT_BUSY]),
        .wr_ien      (bus_wdata[BIT_IEN]),
        .clr_done    (bus_wdata[BIT_DONE]),
        .clr_crc     (bus_wdata[BIT_CRC]),
        .clr_abrt    (bus_wdata[BIT_ABRT]),
        .eng_done    (eng_done),
        .eng_crc_err (eng_crc_err),
        .eng_abort   (eng_abort),
        .busy        (busy),
        .start_pulse (eng_start),
        .ien         (ien),
        .sts         (sts),
        .irq         (irq)
    );

    peci_fe_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (wr && hit_data && !busy),
        .bus_idx   (bus_addr[2 +: IDX_W]),
        .bus_wbyte (bus_wdata[7:0]),
        .eng_we    (eng_rx_we && busy),
        .eng_idx   (eng_rx_idx),
        .eng_wbyte (eng_rx_byte),
        .rd_idx    (bus_addr[2 +: IDX_W]),
        .rd_byte   (data_rd),
        .tx_idx    (eng_tx_idx),
        .tx_byte   (eng_tx_byte)
    );

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_csr) begin
            bus_rdata[BIT_BUSY] = busy;
            bus_rdata[BIT_DONE] = sts.done;
            bus_rdata[BIT_CRC]  = sts.crc;
            bus_rdata[BIT_ABRT] = sts.abrt;
            bus_rdata[BIT_IEN]  = ien;
        end
        else if (hit_rdlen) bus_rdata[6:0] = rdlen_q;
        else if (hit_tgt)   bus_rdata[7:0] = tgt_q;
        else if (hit_cmd)   bus_rdata[7:0] = cmd_q;
        else if (hit_pull)  bus_rdata[7:6] = pull_q;
        else if (hit_wrlen) bus_rdata[6:0] = wrlen_q;
        else if (hit_rate)  bus_rdata[4:0] = rate_q;
        else if (hit_data)  bus_rdata[7:0] = data_rd;
    end

    // Engine-facing settings.
    always_comb begin
        eng_tgt    = tgt_q;
        eng_cmd    = cmd_q;
        eng_wr_len = wrlen_q;
        eng_rd_len = rdlen_q;
        eng_rate   = rate_q;
        eng_pulldn = pull_q;
    end

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(tgt_q) && $stable(cmd_q) && $stable(rdlen_q) && $stable(wrlen_q)));
endmodule

// File: tb/peci_host_frontend_tb_top.sv
`timescale 1ns/1ps
module peci_host_frontend_tb_top;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = 4;

    // {tgt, cmd, wlen, rlen, flags(bit9 crc, bit8 abort), seed}
    localparam logic [47:0] VEC [4] = '{
        48'h30_01_01_02_00_A0,
        48'h31_A1_05_04_02_10,
        48'h32_B5_03_00_01_55,
        48'h30_0F_10_10_03_00
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic              eng_start;
    logic [7:0]        eng_tgt, eng_cmd, eng_tx_byte;
    logic [6:0]        eng_wr_len, eng_rd_len;
    logic [4:0]        eng_rate;
    logic [1:0]        eng_pulldn;
    logic [IDX_W-1:0]  eng_tx_idx = '0, eng_rx_idx = '0;
    logic              eng_rx_we = 1'b0;
    logic [7:0]        eng_rx_byte = '0;
    logic              eng_done = 1'b0, eng_crc_err = 1'b0, eng_abort = 1'b0;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    peci_host_frontend #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_xfer(input logic crc, input logic ab);
        @(negedge clk);
        eng_done = 1'b1; eng_crc_err = crc; eng_abort = ab;
        @(negedge clk);
        eng_done = 1'b0; eng_crc_err = 1'b0; eng_abort = 1'b0;
    endtask

    task automatic run_tests();
        logic [31:0] d;
        // reset state (R1)
        rd('h00, d); chk("R1 csr", d, 32'h0);
        rd('h2C, d); chk("R1 rate", d, 32'h0F);
        rd('h08, d); chk("R1 tgt", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // vector table walk (R2 R3 R4 R6 R8 R9)
        for (int v = 0; v < 4; v++) begin
            logic [7:0] tgt, cmd, seed;
            logic [6:0] wl, rl;
            logic crc, ab;
            tgt = VEC[v][47:40]; cmd = VEC[v][39:32];
            wl = VEC[v][30:24]; rl = VEC[v][22:16];
            crc = VEC[v][9]; ab = VEC[v][8]; seed = VEC[v][7:0];
            wr('h00, 32'h5A);
            wr('h08, {24'h0, tgt});
            wr('h0C, {24'h0, cmd});
            wr('h1C, {25'h0, wl});
            wr('h04, {25'h0, rl});
            for (int i = 0; i + 1 < int'(wl); i++)
                wr('h100 + 4*i, {24'h0, seed ^ 8'h5A ^ 8'(i)});
            rd('h1C, d); chk("R8 wrlen readback", d, {25'h0, wl});
            wr('h00, 32'h41);
            chk("R2 start pulse", {31'b0, eng_start}, 32'h1);
            chk("R2 eng fields", {eng_tgt, eng_cmd, 1'b0, eng_wr_len, 1'b0, eng_rd_len},
                {tgt, cmd, 1'b0, wl, 1'b0, rl});
            @(negedge clk);
            chk("R2 single pulse", {31'b0, eng_start}, 32'h0);
            rd('h00, d); chk("R3 busy", d, 32'h41);
            for (int i = 0; i + 1 < int'(wl); i++) begin
                eng_tx_idx = IDX_W'(i);
                #1 chk("R9 tx byte", {24'h0, eng_tx_byte}, {24'h0, seed ^ 8'h5A ^ 8'(i)});
            end
            for (int i = 0; i < int'(rl); i++) begin
                @(negedge clk);
                eng_rx_we = 1'b1; eng_rx_idx = IDX_W'(i); eng_rx_byte = seed + 8'(i);
            end
            @(negedge clk); eng_rx_we = 1'b0;
            finish_xfer(crc, ab);
            rd('h00, d);
            chk("R4 status", d, {25'h0, 1'b1, 1'b0, ab, crc, 1'b0, 1'b1, 1'b0});
            chk("R6 irq set", {31'b0, irq}, 32'h1);
            for (int i = 0; i < int'(rl); i++) begin
                rd('h100 + 4*i, d); chk("R9 rx byte", d, {24'h0, seed + 8'(i)});
            end
            wr('h00, 32'h5A);
            chk("R5 cleared irq", {31'b0, irq}, 32'h0);
        end

        // R5: writing zero keeps bits; set wins over clear
        wr('h08, 32'h77);
        wr('h00, 32'h01);
        finish_xfer(1'b1, 1'b0);
        wr('h00, 32'h00);
        rd('h00, d); chk("R5 zero write keeps", d, 32'h0A);
        chk("R6 irq off when disabled", {31'b0, irq}, 32'h0);
        wr('h00, 32'h40);
        chk("R6 irq on after enable", {31'b0, irq}, 32'h1);
        wr('h00, 32'h48);
        rd('h00, d); chk("R5 clear crc only", d, 32'h42);
        wr('h00, 32'h43);  // clears done, starts
        // R7: writes while busy
        wr('h00, 32'h41);
        chk("R7 no restart", {31'b0, eng_start}, 32'h0);
        wr('h08, 32'hEE);
        wr('h100, 32'hCC);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'('h00); bus_wdata = 32'h5A;
        eng_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; eng_done = 1'b0;
        rd('h00, d); chk("R5 set wins over clear", d, 32'h42);
        rd('h08, d); chk("R7 tgt frozen", d, 32'h77);
        rd('h100, d); chk("R7 data frozen", d, 32'h00);

        // R10 line settings
        wr('h10, 32'hFF);
        rd('h10, d); chk("R10 pull", d, 32'hC0);
        chk("R10 eng pull", {30'b0, eng_pulldn}, 32'h3);
        wr('h2C, 32'hFF);
        rd('h2C, d); chk("R10 rate", d, 32'h1F);

        // R11 unmapped
        wr('h18, 32'hFF);
        rd('h18, d); chk("R11 hole reads 0", d, 32'h0);
        wr('h140, 32'h99);
        rd('h140, d); chk("R11 beyond bank", d, 32'h0);
        rd('h100, d); chk("R11 slot0 untouched", d, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL R3 watchdog act=running exp=finished");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule